// File: doc/BRIEF.md
# Capture Line Address Generator

This block produces the memory base address for each line that an image sensor capture path writes. It supports progressive and interlaced frames. It moves from line to line by a signed step that depends on the line's parity and the field being captured, rather than by a fixed pitch. A capture engine uses the address as the start of the burst for the current line. Firmware writes the configuration before a frame begins.

A rising edge on the vertical sync reloads the address from a start value. The start value is split into upper and lower halves. When the current field is the odd one (effective field 1), a start displacement of one to four lines is added. A rising edge on the horizontal sync moves the address by one of four programmed line offsets, each from -4 to +4 lines, scaled by the line pitch. A direction control reverses the sign of every displacement. A field-inversion control flips the incoming field identifier before it is used. The block also reports the number of lines since the last vertical sync and the field it latched.

Top module: `capline_addr_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, line_addr, line_count and field_out are all zero.
- R2: In the cycle after a rising edge of vsync with effective field 0, line_addr equals {cfg_start_hi, cfg_start_lo}.
- R3: In the cycle after a rising edge of vsync with effective field 1, line_addr equals the start address plus (cfg_odd_start + 1) × cfg_pitch × 32. The displacement is subtracted instead when cfg_dir_down is 1.
- R4: The effective field is fid_in XOR cfg_fld_inv. It is latched into field_out only on a rising edge of vsync, and changes of fid_in at other times have no effect.
- R5: In the cycle after a rising edge of hsync, line_addr moves by N × cfg_pitch × 32 bytes. A 3-bit code selects N: codes 0–3 give +1 to +4 and codes 4–7 give −1 to −4. The code comes from cfg_ofs_e0 (field 0, even line), cfg_ofs_o0 (field 0, odd line), cfg_ofs_e1 (field 1, even line) or cfg_ofs_o1 (field 1, odd line). Parity is bit 0 of line_count before the step. cfg_dir_down = 1 negates the move.
- R6: line_count is cleared to 0 by a rising edge of vsync and increments by one on each rising edge of hsync.
- R7: All address arithmetic wraps modulo 2^ADDR_W.
- R8: Only rising edges act. While both syncs are held at a constant level, line_addr, line_count and field_out do not change.
- R9: When vsync and hsync rise in the same cycle, the vsync reload takes effect and the hsync step is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start_hi | input | ADDR_W/2 | Upper half of frame start address |
| cfg_start_lo | input | ADDR_W/2 | Lower half of frame start address |
| cfg_pitch | input | PITCH_W | Line pitch in 32-byte units |
| cfg_dir_down | input | 1 | 1: displacements are subtracted |
| cfg_odd_start | input | 2 | Odd-field start displacement code (+1..+4 lines) |
| cfg_ofs_e0 | input | 3 | Step code, field 0, even line |
| cfg_ofs_o0 | input | 3 | Step code, field 0, odd line |
| cfg_ofs_e1 | input | 3 | Step code, field 1, even line |
| cfg_ofs_o1 | input | 3 | Step code, field 1, odd line |
| cfg_fld_inv | input | 1 | Invert incoming field identifier |
| vsync | input | 1 | Vertical sync level |
| hsync | input | 1 | Horizontal sync level |
| fid_in | input | 1 | Field identifier |
| line_addr | output | ADDR_W | Current line base address (bytes) |
| line_count | output | LCNT_W | Lines stepped since last vertical sync |
| field_out | output | 1 | Latched effective field |

## Verification
The bench targets four kinds of error:
- Offset selection. It drives all four parity/field slot combinations. A design that swapped two slots, or that took parity after incrementing the counter, would step by the wrong number of lines.
- Field inversion. It applies inversion with both field values. A design that ignored cfg_fld_inv, or that sampled the field outside vsync, would load the wrong start address or report the wrong field.
- Wrap-around and direction. It steps the address across zero in both directions. A design with a narrow adder or an inverted sign would leave the expected address.
- Sync behaviour. It holds syncs high over several cycles and raises both syncs together. A level-sensitive design would step repeatedly, and a design with reversed priority would leave a non-zero line count.

// File: rtl/capline_pkg.sv
package capline_pkg;

  // Offset slot, indexed by {field, line parity}
  typedef enum logic [1:0] {
    SLOT_F0_EVEN = 2'b00,
    SLOT_F0_ODD  = 2'b01,
    SLOT_F1_EVEN = 2'b10,
    SLOT_F1_ODD  = 2'b11
  } ofs_slot_e;

  // 3-bit step code: bit 2 is the sign, bits 1:0 hold magnitude minus one
  typedef logic [2:0] step_code_t;

  localparam int unsigned GRAN_SHIFT = 5;  // pitch granule is 32 bytes

endpackage

// File: rtl/capline_edge_det.sv
module capline_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl[i];
    end

    assign rise[i] = lvl[i] & ~prev_q;
  end

endmodule

// File: rtl/capline_ofs_sel.sv
module capline_ofs_sel
  import capline_pkg::*;
(
  input  logic       field,
  input  logic       parity,
  input  step_code_t code_f0_even,
  input  step_code_t code_f0_odd,
  input  step_code_t code_f1_even,
  input  step_code_t code_f1_odd,
  output step_code_t code_sel
);

  ofs_slot_e slot;

  always_comb begin
    slot = ofs_slot_e'({field, parity});
    unique case (slot)
      SLOT_F0_EVEN: code_sel = code_f0_even;
      SLOT_F0_ODD:  code_sel = code_f0_odd;
      SLOT_F1_EVEN: code_sel = code_f1_even;
      SLOT_F1_ODD:  code_sel = code_f1_odd;
      default:      code_sel = code_f0_even;
    endcase
  end

endmodule

// File: rtl/capline_step_calc.sv
module capline_step_calc
  import capline_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PITCH_W = 12
) (
  input  step_code_t          code,
  input  logic [PITCH_W-1:0]  pitch,
  input  logic                dir_down,
  output logic [ADDR_W-1:0]   delta
);

  localparam int unsigned MAG_W = PITCH_W + 3 + GRAN_SHIFT;

  logic [2:0]        lines;
  logic [MAG_W-1:0]  mag;
  logic              negate;
  logic [ADDR_W-1:0] mag_ext;

  always_comb begin
    lines   = {1'b0, code[1:0]} + 3'd1;
    mag     = (MAG_W'(lines) * MAG_W'(pitch)) << GRAN_SHIFT;
    negate  = code[2] ^ dir_down;
    mag_ext = ADDR_W'(mag);
    delta   = negate ? (ADDR_W'(0) - mag_ext) : mag_ext;
  end

endmodule

// File: rtl/capline_addr_gen.sv
module capline_addr_gen
  import capline_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PITCH_W = 12,
  parameter int unsigned LCNT_W  = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W/2-1:0] cfg_start_hi,
  input  logic [ADDR_W/2-1:0] cfg_start_lo,
  input  logic [PITCH_W-1:0]  cfg_pitch,
  input  logic                cfg_dir_down,
  input  logic [1:0]          cfg_odd_start,
  input  logic [2:0]          cfg_ofs_e0,
  input  logic [2:0]          cfg_ofs_o0,
  input  logic [2:0]          cfg_ofs_e1,
  input  logic [2:0]          cfg_ofs_o1,
  input  logic                cfg_fld_inv,
  input  logic                vsync,
  input  logic                hsync,
  input  logic                fid_in,
  output logic [ADDR_W-1:0]   line_addr,
  output logic [LCNT_W-1:0]   line_count,
  output logic                field_out
);

  localparam int unsigned HALF_W = ADDR_W / 2;

  // sync edge detection
  logic [1:0] sync_rise;
  logic       vs_rise;
  logic       hs_rise;

  capline_edge_det #(.N(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   ({vsync, hsync}),
    .rise  (sync_rise)
  );

  assign vs_rise = sync_rise[1];
  assign hs_rise = sync_rise[0];

  // state
  logic [ADDR_W-1:0] addr_q, addr_nx;
  logic [LCNT_W-1:0] cnt_q,  cnt_nx;
  logic              fld_q,  fld_nx;
  logic              addr_en;

  // step selection for the current line
  step_code_t        line_code;
  logic [ADDR_W-1:0] line_delta;
  logic [ADDR_W-1:0] odd_delta;
  logic              field_now;
  logic [ADDR_W-1:0] start_addr;

  capline_ofs_sel u_sel (
    .field        (fld_q),
    .parity       (cnt_q[0]),
    .code_f0_even (cfg_ofs_e0),
    .code_f0_odd  (cfg_ofs_o0),
    .code_f1_even (cfg_ofs_e1),
    .code_f1_odd  (cfg_ofs_o1),
    .code_sel     (line_code)
  );

  capline_step_calc #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) u_line_step (
    .code     (line_code),
    .pitch    (cfg_pitch),
    .dir_down (cfg_dir_down),
    .delta    (line_delta)
  );

  capline_step_calc #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) u_odd_step (
    .code     ({1'b0, cfg_odd_start}),
    .pitch    (cfg_pitch),
    .dir_down (cfg_dir_down),
    .delta    (odd_delta)
  );

  assign field_now  = fid_in ^ cfg_fld_inv;
  assign start_addr = {cfg_start_hi[HALF_W-1:0], cfg_start_lo[HALF_W-1:0]};

  // next state: vertical sync takes priority over horizontal sync
  always_comb begin
    addr_nx = addr_q;
    cnt_nx  = cnt_q;
    fld_nx  = fld_q;
    addr_en = 1'b0;
    if (vs_rise) begin
      addr_en = 1'b1;
      addr_nx = start_addr + (field_now ? odd_delta : '0);
      cnt_nx  = '0;
      fld_nx  = field_now;
    end else if (hs_rise) begin
      addr_en = 1'b1;
      addr_nx = addr_q + line_delta;
      cnt_nx  = cnt_q + LCNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      fld_q  <= 1'b0;
    end else if (addr_en) begin
      addr_q <= addr_nx;
      cnt_q  <= cnt_nx;
      fld_q  <= fld_nx;
    end
  end

  assign line_addr  = addr_q;
  assign line_count = cnt_q;
  assign field_out  = fld_q;

endmodule

// File: rtl/capline_addr_gen_chk.sv
module capline_addr_gen_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LCNT_W  = 13
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W/2-1:0] cfg_start_hi,
  input logic [ADDR_W/2-1:0] cfg_start_lo,
  input logic                cfg_fld_inv,
  input logic                vsync,
  input logic                hsync,
  input logic                fid_in,
  input logic [ADDR_W-1:0]   line_addr,
  input logic [LCNT_W-1:0]   line_count,
  input logic                field_out
);

  logic vs_d, hs_d;
  logic vs_r, hs_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_d <= 1'b0;
      hs_d <= 1'b0;
    end else begin
      vs_d <= vsync;
      hs_d <= hsync;
    end
  end

  assign vs_r = vsync & ~vs_d;
  assign hs_r = hsync & ~hs_d;

  a_r2_reload_start: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_r && !(fid_in ^ cfg_fld_inv)) |=> (line_addr == $past({cfg_start_hi, cfg_start_lo})));

  a_r4_field_latch: assert property (@(posedge clk) disable iff (!rst_n)
    vs_r |=> (field_out == $past(fid_in ^ cfg_fld_inv)));

  a_r6_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    vs_r |=> (line_count == '0));

  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_r && !vs_r) |=> (line_count == LCNT_W'($past(line_count) + LCNT_W'(1))));

  a_r8_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!vs_r && !hs_r) |=> ($stable(line_addr) && $stable(line_count) && $stable(field_out)));

endmodule

bind capline_addr_gen capline_addr_gen_chk #(.ADDR_W(ADDR_W), .LCNT_W(LCNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_start_hi (cfg_start_hi),
  .cfg_start_lo (cfg_start_lo),
  .cfg_fld_inv  (cfg_fld_inv),
  .vsync        (vsync),
  .hsync        (hsync),
  .fid_in       (fid_in),
  .line_addr    (line_addr),
  .line_count   (line_count),
  .field_out    (field_out)
);

// File: tb/capline_addr_gen_bench.sv
module capline_addr_gen_bench;

  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned PITCH_W = 12;
  localparam int unsigned LCNT_W  = 13;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [15:0]         cfg_start_hi, cfg_start_lo;
  logic [PITCH_W-1:0]  cfg_pitch;
  logic                cfg_dir_down;
  logic [1:0]          cfg_odd_start;
  logic [2:0]          cfg_ofs_e0, cfg_ofs_o0, cfg_ofs_e1, cfg_ofs_o1;
  logic                cfg_fld_inv;
  logic                vsync, hsync, fid_in;
  logic [ADDR_W-1:0]   line_addr;
  logic [LCNT_W-1:0]   line_count;
  logic                field_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [31:0] exp_addr;
  logic [31:0] exp_cnt;
  logic        exp_fld;

  always #10 clk = ~clk;

  capline_addr_gen #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .LCNT_W(LCNT_W)) u_capline_addr_gen (
    .clk (clk), .rst_n (rst_n),
    .cfg_start_hi (cfg_start_hi), .cfg_start_lo (cfg_start_lo),
    .cfg_pitch (cfg_pitch), .cfg_dir_down (cfg_dir_down),
    .cfg_odd_start (cfg_odd_start),
    .cfg_ofs_e0 (cfg_ofs_e0), .cfg_ofs_o0 (cfg_ofs_o0),
    .cfg_ofs_e1 (cfg_ofs_e1), .cfg_ofs_o1 (cfg_ofs_o1),
    .cfg_fld_inv (cfg_fld_inv),
    .vsync (vsync), .hsync (hsync), .fid_in (fid_in),
    .line_addr (line_addr), .line_count (line_count), .field_out (field_out)
  );

  // displacement in bytes for a 3-bit code, per R3/R5
  function automatic logic [31:0] disp(input logic [2:0] code);
    logic [31:0] m;
    m = (32'(code[1:0]) + 32'd1) * 32'(cfg_pitch) * 32'd32;
    return (code[2] ^ cfg_dir_down) ? (32'd0 - m) : m;
  endfunction

  function automatic logic [2:0] pick(input logic f, input logic p);
    case ({f, p})
      2'b00:   return cfg_ofs_e0;
      2'b01:   return cfg_ofs_o0;
      2'b10:   return cfg_ofs_e1;
      default: return cfg_ofs_o1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " addr"},  line_addr, exp_addr);
    chk({tag, " count"}, 32'(line_count), exp_cnt);
    chk({tag, " field"}, 32'(field_out), 32'(exp_fld));
  endtask

  task automatic pulse_vs(input logic fid, input string tag);
    @(negedge clk);
    fid_in  = fid;
    vsync   = 1'b1;
    exp_fld = fid ^ cfg_fld_inv;
    exp_addr = {cfg_start_hi, cfg_start_lo} + (exp_fld ? disp({1'b0, cfg_odd_start}) : 32'd0);
    exp_cnt = 0;
    @(negedge clk);
    vsync = 1'b0;
    chk_all(tag);
  endtask

  task automatic pulse_hs(input string tag);
    @(negedge clk);
    hsync    = 1'b1;
    exp_addr = exp_addr + disp(pick(exp_fld, exp_cnt[0]));
    exp_cnt  = exp_cnt + 1;
    @(negedge clk);
    hsync = 1'b0;
    chk_all(tag);
  endtask

  task automatic set_cfg(input logic [31:0] start, input logic [11:0] pitch, input logic dn);
    cfg_start_hi  = start[31:16];
    cfg_start_lo  = start[15:0];
    cfg_pitch     = pitch;
    cfg_dir_down  = dn;
  endtask

  // R1
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    exp_addr = 0; exp_cnt = 0; exp_fld = 0;
    chk_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after reset");
  endtask

  // R2, R5, R6: field 0 progressive stepping
  task automatic t_field0_up();
    set_cfg(32'h1000_0400, 12'h040, 1'b0);
    cfg_fld_inv = 1'b0;
    pulse_vs(1'b0, "R2 field0 reload");
    for (int i = 0; i < 4; i++) pulse_hs("R5 field0 step");
    pulse_vs(1'b0, "R6 count clear");
  endtask

  // R3, R5: odd field start and field-1 slots, up then down
  task automatic t_field1();
    set_cfg(32'h2000_0000, 12'h021, 1'b0);
    pulse_vs(1'b1, "R3 odd start up");
    for (int i = 0; i < 4; i++) pulse_hs("R5 field1 step");
    set_cfg(32'h2000_0000, 12'h021, 1'b1);
    pulse_vs(1'b1, "R3 odd start down");
    for (int i = 0; i < 3; i++) pulse_hs("R5 field1 step down");
  endtask

  // R4: inversion and mid-frame field changes
  task automatic t_inversion();
    set_cfg(32'h0040_0000, 12'h010, 1'b0);
    cfg_fld_inv = 1'b1;
    pulse_vs(1'b1, "R4 inv fid1 -> field0");
    pulse_vs(1'b0, "R4 inv fid0 -> field1");
    fid_in = 1'b1;
    pulse_hs("R4 fid change ignored");
    fid_in = 1'b0;
    pulse_hs("R4 fid change ignored 2");
    cfg_fld_inv = 1'b0;
  endtask

  // R7: wrap both directions
  task automatic t_wrap();
    set_cfg(32'hFFFF_FF00, 12'h008, 1'b0);
    pulse_vs(1'b0, "R7 reload near top");
    pulse_hs("R7 wrap up");
    set_cfg(32'h0000_0000, 12'h008, 1'b1);
    pulse_vs(1'b0, "R7 reload zero");
    pulse_hs("R7 wrap down");
  endtask

  // R8: held levels do not repeat
  task automatic t_level_hold();
    set_cfg(32'h0800_0000, 12'h100, 1'b0);
    pulse_vs(1'b0, "R8 reload");
    @(negedge clk);
    hsync    = 1'b1;
    exp_addr = exp_addr + disp(pick(exp_fld, exp_cnt[0]));
    exp_cnt  = exp_cnt + 1;
    repeat (4) @(negedge clk);
    chk_all("R8 hsync held");
    vsync = 1'b1;
    fid_in = 1'b1;
    exp_fld = 1'b1;
    exp_addr = {cfg_start_hi, cfg_start_lo} + disp({1'b0, cfg_odd_start});
    exp_cnt = 0;
    repeat (4) @(negedge clk);
    chk_all("R8 vsync held");
    hsync = 1'b0; vsync = 1'b0;
    repeat (2) @(negedge clk);
    chk_all("R8 falling edges");
  endtask

  // R9: simultaneous edges
  task automatic t_simul();
    set_cfg(32'h0300_0000, 12'h00C, 1'b0);
    pulse_vs(1'b0, "R9 setup");
    pulse_hs("R9 setup step");
    @(negedge clk);
    vsync = 1'b1; hsync = 1'b1; fid_in = 1'b0;
    exp_fld = 1'b0; exp_addr = {cfg_start_hi, cfg_start_lo}; exp_cnt = 0;
    @(negedge clk);
    vsync = 1'b0; hsync = 1'b0;
    chk_all("R9 vsync wins");
  endtask

  initial begin
    rst_n = 1'b0;
    vsync = 0; hsync = 0; fid_in = 0;
    cfg_odd_start = 2'd2;
    cfg_ofs_e0 = 3'd0; cfg_ofs_o0 = 3'd1; cfg_ofs_e1 = 3'd5; cfg_ofs_o1 = 3'd3;
    cfg_fld_inv = 1'b0;
    set_cfg(32'h0, 12'h0, 1'b0);
    t_reset();
    t_field0_up();
    t_field1();
    t_inversion();
    t_wrap();
    t_level_hold();
    t_simul();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule